// File: doc/BRIEF.md
# Coin Vending Machine Controller

This block is the decision core of a coin-operated vending machine selling a single item priced at 40c. Each clock cycle it may receive at most one coin (nickel, dime or quarter) as a 2-bit code. It keeps the credit inserted so far as a count of 5c units, from 0c up to 35c. The outputs are decided in the same cycle as the coin, so the controller is a Mealy machine.

A coin that leaves the total below the price is added to the credit. A coin that brings the total to between 40c and 50c releases the item, hands back the excess as one coin, and clears the credit. A coin that would take the total past 50c is refused: the same coin is handed straight back and the credit does not change. Coin sensing, the dispensing mechanism and change made of several coins are handled elsewhere.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While rst_ni is low, change_o is 00 and vend_o is 0. On release of reset the stored credit is 0c.
- R2: With coin_i = 00 (no coin), change_o is 00, vend_o is 0 and the credit is unchanged at the next edge.
- R3: A coin with credit plus coin value below 40c raises the credit by the coin value at the next edge, with change_o = 00 and vend_o = 0.
- R4: A coin with credit plus coin value from 40c to 50c drives vend_o = 1 and change_o = the code of (total - 40c): 00 for 0c, 01 for 5c, 10 for 10c. The credit becomes 0c at the next edge.
- R5: A coin with credit plus coin value above 50c drives change_o equal to coin_i and vend_o = 0, and the credit is unchanged at the next edge.
- R6: change_o and vend_o respond to coin_i in the same cycle, before the clock edge that updates the credit.
- R7: The coin code on coin_i and change_o is 00 = none, 01 = 5c, 10 = 10c, 11 = 25c.
- R8: vend_o = 1 never appears together with change_o = 11; a returned quarter only happens on a refused coin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coin_i | input | 2 | Coin inserted this cycle (R7 code) |
| change_o | output | 2 | Coin handed back this cycle (R7 code) |
| vend_o | output | 1 | Release one item this cycle |

## Verification
Delivering the item and returning change fall in the same cycle whenever a coin overshoots 40c, and refusing a coin shares the change output with that change return. The bench reaches every credit value from 0c to 35c with a run of nickels, applies each coin code there, and judges the outputs against an arithmetic model within the same cycle; it then sends probe nickels until the next sale to confirm the credit left behind. Random coin streams follow, checked cycle by cycle against the same model.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;
  typedef enum logic [1:0] {
    COIN_NONE    = 2'b00,
    COIN_NICKEL  = 2'b01,
    COIN_DIME    = 2'b10,
    COIN_QUARTER = 2'b11
  } coin_e;

  // coin values in 5c units
  localparam int NICKEL_U  = 1;
  localparam int DIME_U    = 2;
  localparam int QUARTER_U = 5;

  function automatic coin_e units_to_coin(input int units);
    case (units)
      NICKEL_U:  return COIN_NICKEL;
      DIME_U:    return COIN_DIME;
      QUARTER_U: return COIN_QUARTER;
      default:   return COIN_NONE;
    endcase
  endfunction
endpackage

// File: rtl/coin_value.sv
module coin_value #(
  parameter int UNIT_W = 4
) (
  input  logic [1:0]        coin_i,
  output logic [UNIT_W-1:0] units_o
);
  import coin_vend_pkg::*;

  always_comb begin
    case (coin_e'(coin_i))
      COIN_NICKEL:  units_o = UNIT_W'(NICKEL_U);
      COIN_DIME:    units_o = UNIT_W'(DIME_U);
      COIN_QUARTER: units_o = UNIT_W'(QUARTER_U);
      default:      units_o = '0;
    endcase
  end
endmodule

// File: rtl/vend_decide.sv
module vend_decide #(
  parameter int CRED_W  = 3,
  parameter int SUM_W   = 5,
  parameter int PRICE_U = 8,
  parameter int LIMIT_U = 10
) (
  input  logic [1:0]        coin_i,
  input  logic [SUM_W-1:0]  units_i,
  input  logic [CRED_W-1:0] credit_q_i,
  output logic [CRED_W-1:0] credit_d_o,
  output logic [1:0]        change_o,
  output logic              vend_o
);
  import coin_vend_pkg::*;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] excess;

  assign sum    = SUM_W'(credit_q_i) + units_i;
  assign excess = sum - SUM_W'(PRICE_U);

  always_comb begin
    credit_d_o = credit_q_i;
    change_o   = COIN_NONE;
    vend_o     = 1'b0;
    if (coin_e'(coin_i) != COIN_NONE) begin
      if (sum > SUM_W'(LIMIT_U)) begin
        change_o = coin_i;           // refuse: hand the same coin back
      end else if (sum >= SUM_W'(PRICE_U)) begin
        vend_o     = 1'b1;
        credit_d_o = '0;
        change_o   = units_to_coin(int'(excess));
      end else begin
        credit_d_o = sum[CRED_W-1:0];
      end
    end
  end
endmodule

// File: rtl/credit_reg.sv
module credit_reg #(
  parameter int CRED_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CRED_W-1:0] credit_d_i,
  output logic [CRED_W-1:0] credit_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) credit_q_o <= '0;
    else         credit_q_o <= credit_d_i;
  end
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl #(
  parameter int PRICE_U = 8,   // 40c
  parameter int LIMIT_U = 10   // 50c
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] coin_i,
  output logic [1:0] change_o,
  output logic       vend_o
);
  localparam int CRED_W = $clog2(PRICE_U);
  localparam int SUM_W  = $clog2(LIMIT_U + 8) + 1;

  logic [SUM_W-1:0]  units;
  logic [CRED_W-1:0] credit_q;
  logic [CRED_W-1:0] credit_d;

  coin_value #(.UNIT_W(SUM_W)) u_value (
    .coin_i  (coin_i),
    .units_o (units)
  );

  vend_decide #(
    .CRED_W  (CRED_W),
    .SUM_W   (SUM_W),
    .PRICE_U (PRICE_U),
    .LIMIT_U (LIMIT_U)
  ) u_decide (
    .coin_i     (coin_i),
    .units_i    (units),
    .credit_q_i (credit_q),
    .credit_d_o (credit_d),
    .change_o   (change_o),
    .vend_o     (vend_o)
  );

  credit_reg #(.CRED_W(CRED_W)) u_credit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .credit_d_i (credit_d),
    .credit_q_o (credit_q)
  );
endmodule

// File: rtl/coin_vend_chk.sv
module coin_vend_chk #(
  parameter int CRED_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        coin_i,
  input logic [1:0]        change_o,
  input logic              vend_o,
  input logic [CRED_W-1:0] credit_q
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (change_o == 2'b00 && !vend_o));

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coin_i == 2'b00 |-> (change_o == 2'b00 && !vend_o));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coin_i == 2'b00 |=> credit_q == $past(credit_q));

  assert_accept_grows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coin_i != 2'b00 && change_o == 2'b00 && !vend_o) |=> credit_q > $past(credit_q));

  assert_vend_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vend_o |=> credit_q == '0);

  assert_refuse_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (change_o != 2'b00 && !vend_o) |=> credit_q == $past(credit_q));

  assert_refuse_echo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (change_o != 2'b00 && !vend_o) |-> change_o == coin_i);

  assert_no_quarter_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vend_o |-> change_o != 2'b11);
endmodule

bind coin_vend_ctrl coin_vend_chk #(.CRED_W(CRED_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .coin_i   (coin_i),
  .change_o (change_o),
  .vend_o   (vend_o),
  .credit_q (credit_q)
);

// File: tb/coin_vend_ctrl_bench.sv
`timescale 1ns/1ps
module coin_vend_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] coin_i = 2'b00;
  logic [1:0] change_o;
  logic       vend_o;

  int checks = 0;
  int failures = 0;
  int model_cr = 0;   // credit in 5c units
  bit done = 1'b0;

  coin_vend_ctrl u_coin_vend_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .coin_i   (coin_i),
    .change_o (change_o),
    .vend_o   (vend_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic int val_of(input logic [1:0] c);
    case (c)
      2'b01: return 1;
      2'b10: return 2;
      2'b11: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic [1:0] chg, input logic vnd);
    checks++;
    if (change_o !== chg || vend_o !== vnd) begin
      failures++;
      $display("FAIL %s: change=%b vend=%b expected change=%b vend=%b (credit %0dc)",
               req, change_o, vend_o, chg, vnd, model_cr * 5);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    coin_i = 2'b00;
    #1 check("R1", 2'b00, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_cr = 0;
  endtask

  // drive a coin at the falling edge; outputs checked before the next rising edge (R6)
  task automatic apply(input logic [1:0] c, output logic vended);
    int tot;
    @(negedge clk_i);
    coin_i = c;
    #1;
    tot = model_cr + val_of(c);
    vended = 1'b0;
    if (c == 2'b00) begin
      check("R2", 2'b00, 1'b0);
    end else if (tot > 10) begin
      check("R5", c, 1'b0);
    end else if (tot >= 8) begin
      check("R4", (tot == 8) ? 2'b00 : (tot == 9) ? 2'b01 : 2'b10, 1'b1);
      checks++;
      if (vend_o === 1'b1 && change_o === 2'b11) begin
        failures++;
        $display("FAIL R8: change=%b vend=%b expected change!=11", change_o, vend_o);
      end
      model_cr = 0;
      vended = 1'b1;
    end else begin
      check("R3", 2'b00, 1'b0);
      model_cr = tot;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic v;
    // R7 codes: 00 none, 01 5c, 10 10c, 11 25c; sweep every credit and coin
    for (int cr = 0; cr < 8; cr++) begin
      for (int k = 0; k < 4; k++) begin
        do_reset();
        for (int n = 0; n < cr; n++) apply(2'b01, v);
        apply(2'b00, v);              // R2 idle holds
        apply(2'(k), v);              // coin under test
        apply(2'b00, v);
        // probe remaining credit (R1 after reset, R3/R4/R5 after the test coin)
        v = 1'b0;
        for (int n = 0; n < 9 && !v; n++) apply(2'b01, v);
      end
    end
    // random streams
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      apply(2'($urandom_range(0, 3)), v);
      if (i % 997 == 500) do_reset();
    end
    @(negedge clk_i);
    coin_i = 2'b00;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule